// File: doc/BRIEF.md
# Programmable Interval Timer with Snapshot

This block is a 32-bit down-counting interval timer that software drives through a small word-addressed register bus. Software programs a period in two 16-bit halves, picks one-shot or continuous operation, and starts the count. Each time the count expires, a timeout flag is raised, and a level interrupt is driven while that flag and the interrupt enable are both set.

The counter reloads itself with the programmed period on every expiry, so one period lasts the period value plus one clock tick. A write to either snapshot register freezes a copy of the live count, which software then reads back as two halves. Start and stop are one-shot command bits in the control register. Each acts only when the present run state allows it.

Reads are combinational from the selected register. Writes take effect on the rising clock edge where the write strobe is high.

Top module: `interval_timer`

## Requirements
- R1: After reset every register reads zero, the timer is stopped and `irq` is low.
- R2: The register select is byte address bits [4:2]: 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Address bits [1:0] are ignored. Selects 6 and 7 read zero, and writes to them change nothing.
- R3: Status reads return the timeout flag in bit 0 and the run flag in bit 1. Any write to status clears the timeout flag, whatever the data. An expiry on the same edge takes precedence and leaves the flag set.
- R4: Control keeps only interrupt enable (bit 0) and continuous mode (bit 1). Bit 2 (start) and bit 3 (stop) are commands and always read back as zero.
- R5: Start sets the run flag only when the timer is stopped. A start while the timer runs has no effect.
- R6: Stop clears the run flag only when the timer is running.
- R7: A period write stores the low 16 data bits and stops the timer. It also loads the counter with {period high, period low}, so that each period lasts that value plus one tick.
- R8: A write to either snapshot register captures the count present before that edge. The low half goes to snapshot low and the high half to snapshot high.
- R9: While running, the count drops by one per clock. When the count is zero on a running edge, the timeout flag is set and the counter reloads the period. In continuous mode the timer keeps running; otherwise the run flag clears.
- R10: A start with the counter at zero (for example, straight after reset) sets the timeout flag on the first running edge, one tick after the start.
- R11: `irq` is high exactly when the timeout flag and the interrupt enable are both set, and it follows them with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data of the selected register, zero-extended |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 5-bit address, a 32-bit bus and 16-bit halves, which gives a 32-bit counter. Short periods let one-shot and continuous expiries, reloads and restarts occur within a few dozen cycles. A period-high write with non-zero upper data puts a count above 65535 into the snapshot, which exercises the high half of the capture path and the discarding of the upper write data.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PER_LO = 3'd2;
    localparam logic [SEL_W-1:0] SEL_PER_HI = 3'd3;
    localparam logic [SEL_W-1:0] SEL_SNP_LO = 3'd4;
    localparam logic [SEL_W-1:0] SEL_SNP_HI = 3'd5;

    localparam int CTL_IE_BIT    = 0;
    localparam int CTL_CONT_BIT  = 1;
    localparam int CTL_START_BIT = 2;
    localparam int CTL_STOP_BIT  = 3;

    localparam int STS_TO_BIT  = 0;
    localparam int STS_RUN_BIT = 1;

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [HALF_W-1:0] wdata,
    input  logic              expire,
    input  logic [CNT_W-1:0]  count,
    output logic              to_q,
    output logic              ie_q,
    output logic              cont_q,
    output logic [HALF_W-1:0] per_lo_q,
    output logic [HALF_W-1:0] per_hi_q,
    output logic [HALF_W-1:0] snp_lo_q,
    output logic [HALF_W-1:0] snp_hi_q,
    output logic [CNT_W-1:0]  period_nxt,
    output logic              start_cmd,
    output logic              stop_cmd,
    output logic              reload_cmd
);

    typedef struct packed {
        logic              to;
        logic              ie;
        logic              cont;
        logic [HALF_W-1:0] per_lo;
        logic [HALF_W-1:0] per_hi;
        logic [HALF_W-1:0] snp_lo;
        logic [HALF_W-1:0] snp_hi;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        start_cmd  = 1'b0;
        stop_cmd   = 1'b0;
        reload_cmd = 1'b0;
        if (wr) begin
            case (sel)
                SEL_STATUS: r_d.to = 1'b0;
                SEL_CTRL: begin
                    r_d.ie    = wdata[CTL_IE_BIT];
                    r_d.cont  = wdata[CTL_CONT_BIT];
                    start_cmd = wdata[CTL_START_BIT];
                    stop_cmd  = wdata[CTL_STOP_BIT];
                end
                SEL_PER_LO: begin
                    r_d.per_lo = wdata;
                    reload_cmd = 1'b1;
                end
                SEL_PER_HI: begin
                    r_d.per_hi = wdata;
                    reload_cmd = 1'b1;
                end
                SEL_SNP_LO, SEL_SNP_HI: begin
                    r_d.snp_lo = count[HALF_W-1:0];
                    r_d.snp_hi = count[CNT_W-1:HALF_W];
                end
                default: ;
            endcase
        end
        if (expire) begin
            r_d.to = 1'b1;
        end
        period_nxt = {r_d.per_hi, r_d.per_lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign to_q     = r_q.to;
    assign ie_q     = r_q.ie;
    assign cont_q   = r_q.cont;
    assign per_lo_q = r_q.per_lo;
    assign per_hi_q = r_q.per_hi;
    assign snp_lo_q = r_q.snp_lo;
    assign snp_hi_q = r_q.snp_hi;

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             reload_cmd,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    output logic             run_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t c_q, c_d;

    always_comb begin
        c_d    = c_q;
        expire = 1'b0;
        if (c_q.run) begin
            if (c_q.cnt == '0) begin
                expire = 1'b1;
                c_d.cnt = period;
                if (!cont) begin
                    c_d.run = 1'b0;
                end
            end else begin
                c_d.cnt = c_q.cnt - CNT_W'(1);
            end
        end
        if (start_cmd && !c_q.run) begin
            c_d.run = 1'b1;
        end
        if (stop_cmd && c_q.run) begin
            c_d.run = 1'b0;
        end
        if (reload_cmd) begin
            c_d.run = 1'b0;
            c_d.cnt = period;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign run_q = c_q.run;
    assign cnt_q = c_q.cnt;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BUS_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int CNT_W  = 2 * HALF_W;
    localparam int PAD_W  = BUS_W - HALF_W;

    logic [SEL_W-1:0]  sel;
    logic              to_q, ie_q, cont_q, run_q, expire;
    logic [HALF_W-1:0] per_lo_q, per_hi_q, snp_lo_q, snp_hi_q;
    logic [CNT_W-1:0]  period_nxt, cnt_q;
    logic              start_cmd, stop_cmd, reload_cmd;
    logic              unused_bits;

    assign sel         = bus_addr[SEL_W+1:2];
    assign unused_bits = ^{bus_addr, bus_wdata};

    itmr_regs #(.HALF_W(HALF_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .sel        (sel),
        .wdata      (bus_wdata[HALF_W-1:0]),
        .expire     (expire),
        .count      (cnt_q),
        .to_q       (to_q),
        .ie_q       (ie_q),
        .cont_q     (cont_q),
        .per_lo_q   (per_lo_q),
        .per_hi_q   (per_hi_q),
        .snp_lo_q   (snp_lo_q),
        .snp_hi_q   (snp_hi_q),
        .period_nxt (period_nxt),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd),
        .reload_cmd (reload_cmd)
    );

    itmr_counter #(.CNT_W(CNT_W)) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd),
        .reload_cmd (reload_cmd),
        .cont       (cont_q),
        .period     (period_nxt),
        .run_q      (run_q),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_STATUS: begin
                bus_rdata[STS_TO_BIT]  = to_q;
                bus_rdata[STS_RUN_BIT] = run_q;
            end
            SEL_CTRL: begin
                bus_rdata[CTL_IE_BIT]   = ie_q;
                bus_rdata[CTL_CONT_BIT] = cont_q;
            end
            SEL_PER_LO: bus_rdata = {{PAD_W{1'b0}}, per_lo_q};
            SEL_PER_HI: bus_rdata = {{PAD_W{1'b0}}, per_hi_q};
            SEL_SNP_LO: bus_rdata = {{PAD_W{1'b0}}, snp_lo_q};
            SEL_SNP_HI: bus_rdata = {{PAD_W{1'b0}}, snp_hi_q};
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = to_q & ie_q;

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             to_q,
    input logic             run_q,
    input logic             cont_q,
    input logic             expire,
    input logic             start_cmd,
    input logic             stop_cmd,
    input logic             reload_cmd,
    input logic [CNT_W-1:0] cnt_q
);

    AST_EXPIRE_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> to_q);  // R9

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cont_q) |=> !run_q);  // R9

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !reload_cmd) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));  // R9

    AST_RELOAD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        reload_cmd |=> !run_q);  // R7

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !run_q && !reload_cmd) |=> run_q);  // R5

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && run_q) |=> !run_q);  // R6

    AST_IRQ_NEEDS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> to_q);  // R11

endmodule

bind interval_timer itmr_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .to_q       (to_q),
    .run_q      (run_q),
    .cont_q     (cont_q),
    .expire     (expire),
    .start_cmd  (start_cmd),
    .stop_cmd   (stop_cmd),
    .reload_cmd (reload_cmd),
    .cnt_q      (cnt_q)
);

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    interval_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference model state
    bit          m_to, m_run, m_ie, m_cont;
    int unsigned m_pl, m_ph, m_sl, m_sh;
    longint      m_cnt;

    function automatic int unsigned model_read(int s);
        case (s)
            0: return {m_run, m_to};
            1: return {m_cont, m_ie};
            2: return m_pl;
            3: return m_ph;
            4: return m_sl;
            5: return m_sh;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R3";
            1: return "R4";
            2, 3: return "R7";
            4, 5: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, longint got, longint exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic model_step(bit we, int s, int unsigned wd);
        bit     nto = m_to, nrun = m_run, expd = 0;
        longint ncnt = m_cnt;
        if (m_run) begin
            if (m_cnt == 0) begin
                expd = 1;
                ncnt = longint'(m_ph) * 65536 + m_pl;
                if (!m_cont) nrun = 0;
            end else begin
                ncnt = m_cnt - 1;
            end
        end
        if (we) begin
            case (s)
                0: nto = 0;
                1: begin
                    if (wd[2] && !m_run) nrun = 1;
                    if (wd[3] && m_run)  nrun = 0;
                    m_ie   = wd[0];
                    m_cont = wd[1];
                end
                2, 3: begin
                    if (s == 2) m_pl = wd & 32'hFFFF;
                    else        m_ph = wd & 32'hFFFF;
                    nrun = 0;
                    ncnt = longint'(m_ph) * 65536 + m_pl;
                end
                4, 5: begin
                    m_sl = int'(m_cnt % 65536);
                    m_sh = int'(m_cnt / 65536);
                end
                default: ;
            endcase
        end
        if (expd) nto = 1;
        m_to  = nto;
        m_run = nrun;
        m_cnt = ncnt;
    endtask

    // one bus cycle: drive at negedge, compare outputs, advance the model
    task automatic step(bit we, logic [4:0] a, int unsigned wd, string tag = "");
        @(negedge clk);
        bus_wr    = we;
        bus_addr  = a;
        bus_wdata = wd;
        #1;
        check(tag == "" ? tag_of(int'(a[4:2])) : tag, bus_rdata, model_read(int'(a[4:2])));
        check("R11", irq, m_to & m_ie);
        model_step(we, int'(a[4:2]), wd);
    endtask

    task automatic idle(int n, string tag = "R9");
        for (int i = 0; i < n; i++) step(0, 5'h00, 0, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every select
        for (int s = 0; s < 8; s++) step(0, 5'(s * 4), 0, "R1");
        // R10: start at zero count, interrupt enabled
        step(1, 5'h04, 32'h5, "R10");
        step(0, 5'h00, 0, "R10");
        step(0, 5'h00, 0, "R10");
        check("R10", irq, 1);
        // R3: status write with junk clears timeout
        step(1, 5'h00, 32'hFFFF_FFFF, "R3");
        step(0, 5'h00, 0, "R3");
        // R4: control keeps only two bits; R2 low address bits ignored
        step(1, 5'h05, 32'h0000_000F, "R4");
        step(0, 5'h06, 0, "R4");
        step(0, 5'h07, 0, "R2");
        // R7: period low 5, high with upper junk
        step(1, 5'h08, 32'hABCD_0005, "R7");
        step(1, 5'h0C, 32'h1234_0000, "R7");
        step(0, 5'h08, 0, "R7");
        // continuous mode with interrupt, run through several expiries
        step(1, 5'h04, 32'h7, "R5");
        idle(4);
        step(1, 5'h10, 0, "R8");
        step(0, 5'h10, 0, "R8");
        step(0, 5'h14, 0, "R8");
        idle(8);
        // R5: start while running is ignored
        step(1, 5'h04, 32'h7, "R5");
        idle(3, "R5");
        step(1, 5'h00, 0, "R3");
        idle(9);
        // R6: stop while running, then stop while stopped
        step(1, 5'h04, 32'hB, "R6");
        idle(3, "R6");
        step(1, 5'h04, 32'h8, "R6");
        idle(2, "R6");
        // R9: one-shot mode, period 3
        step(1, 5'h08, 32'h3, "R7");
        step(1, 5'h00, 0, "R3");
        step(1, 5'h04, 32'h4, "R9");
        idle(8, "R9");
        // R7: period write while running stops the timer
        step(1, 5'h04, 32'h6, "R7");
        idle(2, "R7");
        step(1, 5'h08, 32'h9, "R7");
        idle(3, "R7");
        // large period: snapshot exercises the high half
        step(1, 5'h0C, 32'hFFFF_0002, "R7");
        step(1, 5'h04, 32'h4, "R8");
        idle(5, "R8");
        step(1, 5'h14, 0, "R8");
        step(0, 5'h10, 0, "R8");
        step(0, 5'h14, 0, "R8");
        // R2: writes to unused selects change nothing
        step(1, 5'h18, 32'hFFFF_FFFF, "R2");
        step(1, 5'h1C, 32'hFFFF_FFFF, "R2");
        for (int s = 0; s < 8; s++) step(0, 5'(s * 4), 0, "R2");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule